// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns characters written by a CPU into an asynchronous serial stream on a single line. It holds one character waiting in a holding register while a second one is being shifted out. This lets software keep the line busy with no gaps, as long as it refills the holding register before the current frame ends.

Each frame opens with a low start bit. The data bits follow, least significant first, with 5 to 8 of them. An optional parity bit comes next, then one or two high stop bits. Serial bit timing comes from a one-cycle strobe that an external baud generator supplies. Two status flags report whether a new character may be written and whether the line has gone fully idle. Single-cycle command inputs turn transmission on and off. A disable never cuts a frame short.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame is sent in this order: one start bit (0), the data bits, the parity bit when parity is on, then the stop bits (1).
- R2: Data bits go out LSB first. The count is 5 + `data_len` (`data_len` 0..3 gives 5..8 bits). Higher bits of `wr_data` beyond that count are not sent.
- R3: `parity_mode` 0 means no parity bit. 1 makes the total number of ones across data and parity even. 2 makes that total odd. 3 sends a 0 and 4 sends a 1. Codes 5 to 7 act as 0.
- R4: `two_stop` = 0 sends one stop bit and 1 sends two. The frame format is captured when a character moves into the shift register.
- R5: `txd` changes only on the clock edge at the end of a cycle in which `bit_tick` is high. Each bit therefore lasts a whole number of tick periods.
- R6: `tx_ready` is high exactly when transmission is enabled and the holding register is free. A write with `wr_en` high while `tx_ready` is low is ignored.
- R7: `tx_empty` is high when nothing is being shifted and the holding register is free. `txd` is then high (mark).
- R8: A character waiting in the holding register moves into the shift register on the tick that ends the last stop bit, with no idle bit between frames. `tx_ready` rises on that same edge.
- R9: When idle and enabled, a written character starts its start bit on the next tick edge.
- R10: `dis_cmd` drops `tx_ready` on the next edge and stops any new frame from starting. A frame already being shifted finishes completely. `en_cmd` resumes transmission. If both commands arrive in the same cycle, disable wins.
- R11: After reset, `txd`, `tx_ready` and `tx_empty` are all high and transmission is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe that marks a bit-time boundary |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| data_len | input | 2 | Data bits minus 5 |
| parity_mode | input | 3 | Parity selection code |
| two_stop | input | 1 | Selects two stop bits |
| txd | output | 1 | Serial output, idle high |
| tx_ready | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Transmitter fully idle |

## Verification
There are two same-cycle collisions that matter. The first is a CPU write landing in the cycle of the tick that ends a frame. The second is a disable command in that same cycle. The bench provokes both by writing whenever the ready flag is seen and by issuing commands on tick cycles as well as between them. A queue-based model of the expected bit stream and flags judges every cycle. It treats a write as accepted only if the flag was high before the edge, and it lets disable block the hand-over from the holding register.

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       en_cmd,
  input  logic       dis_cmd,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] data_len,
  input  logic [2:0] parity_mode,
  input  logic       two_stop,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);
  localparam int FW = 12;

  logic          en_q, hold_full, busy;
  logic [7:0]    hold_data;
  logic [FW-1:0] sh, frame;
  logic [3:0]    cnt, flen;

  wire en_nx = dis_cmd ? 1'b0 : (en_cmd ? 1'b1 : en_q);
  wire last  = ~busy | (cnt == 4'd1);
  wire load  = bit_tick & last & hold_full & en_nx;
  wire take  = wr_en & tx_ready;

  assign tx_ready = en_q & ~hold_full;
  assign tx_empty = ~busy & ~hold_full;
  assign txd      = busy ? sh[0] : 1'b1;

  always_comb begin
    int  n;
    logic ones, pb, has_par;
    n    = 5 + int'(data_len);
    ones = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < n) ones = ones ^ hold_data[i];
    has_par = 1'b1;
    case (parity_mode)
      3'd1:    pb = ones;
      3'd2:    pb = ~ones;
      3'd3:    pb = 1'b0;
      3'd4:    pb = 1'b1;
      default: begin pb = 1'b1; has_par = 1'b0; end
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < n) frame[i+1] = hold_data[i];
    if (has_par) frame[n+1] = pb;
    flen = 4'(1 + n + (has_par ? 1 : 0) + (two_stop ? 2 : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b1;
      hold_full <= 1'b0;
      hold_data <= '0;
      busy      <= 1'b0;
      sh        <= '1;
      cnt       <= '0;
    end else begin
      en_q <= en_nx;
      if (take) begin
        hold_full <= 1'b1;
        hold_data <= wr_data;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (bit_tick) begin
        if (load) begin
          busy <= 1'b1;
          sh   <= frame;
          cnt  <= flen;
        end else if (last) begin
          busy <= 1'b0;
        end else begin
          sh  <= {1'b1, sh[FW-1:1]};
          cnt <= cnt - 4'd1;
        end
      end
    end
  end

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  p_mark_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  p_ignored_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_ready && hold_full) |=> $stable(hold_data));

  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && busy && cnt == 4'd1 && hold_full && en_nx) |=> (busy && !txd && tx_ready == en_q));

  p_disable_drops_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !tx_ready);

  p_frame_not_cut_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> busy);
endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, en_cmd = 1'b0, dis_cmd = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] data_len = 2'd3;
  logic [2:0] parity_mode = '0;
  logic two_stop = 1'b0;
  logic txd, tx_ready, tx_empty;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R11";
  bit done = 1'b0;

  bit m_en = 1'b1, m_full = 1'b0;
  logic [7:0] m_data = '0;
  bit q[$];

  always #5 clk = ~clk;

  uart_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
    .wr_en(wr_en), .wr_data(wr_data), .data_len(data_len), .parity_mode(parity_mode),
    .two_stop(two_stop), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty));

  task automatic build(input logic [7:0] d);
    int n = 5 + int'(data_len);
    int ones = 0;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin q.push_back(d[i]); ones += d[i]; end
    case (parity_mode)
      3'd1: q.push_back(ones % 2 == 1);
      3'd2: q.push_back(ones % 2 == 0);
      3'd3: q.push_back(1'b0);
      3'd4: q.push_back(1'b1);
      default: ;
    endcase
    q.push_back(1'b1);
    if (two_stop) q.push_back(1'b1);
  endtask

  always @(posedge clk) if (rst_n) begin
    bit en_n, rdy;
    en_n = dis_cmd ? 1'b0 : (en_cmd ? 1'b1 : m_en);
    rdy  = m_en && !m_full;
    if (bit_tick) begin
      if (q.size() > 0) void'(q.pop_front());
      if (q.size() == 0 && m_full && en_n) begin build(m_data); m_full = 1'b0; end
    end
    if (wr_en && rdy) begin m_full = 1'b1; m_data = wr_data; end
    m_en = en_n;
  end

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", cur_req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cycles++;
    check("txd", txd, q.size() ? q[0] : 1'b1);
    check("tx_ready", tx_ready, m_en && !m_full);
    check("tx_empty", tx_empty, q.size() == 0 && !m_full);
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : ticker
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      bit_tick = (c == 0);
    end
  end

  task automatic put(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (!(tx_empty && q.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R11";
    check("reset txd", txd, 1'b1);
    check("reset ready", tx_ready, 1'b1);
    check("reset empty", tx_empty, 1'b1);

    cur_req = "R9"; put(8'hA5); drain();
    cur_req = "R2";
    for (int l = 0; l < 4; l++) begin
      data_len = 2'(l); put(8'hF3); put(8'h5C); drain();
    end
    cur_req = "R3";
    for (int p = 0; p < 6; p++) begin
      parity_mode = 3'(p); put(8'h6B); put(8'h01); drain();
    end
    cur_req = "R4"; parity_mode = 3'd1; two_stop = 1'b1; put(8'h80); put(8'h7F); drain();
    cur_req = "R1"; two_stop = 1'b0; data_len = 2'd1; put(8'h00); put(8'hFF); drain();
    cur_req = "R8";
    for (int k = 0; k < 6; k++) put(8'(k * 37 + 11));
    drain();
    cur_req = "R6";
    put(8'h3C); put(8'hC3);
    repeat (20) begin
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hEE;
    end
    @(negedge clk); wr_en = 1'b0; drain();
    cur_req = "R10";
    put(8'h55); put(8'hAA);
    repeat (6) @(negedge clk);
    dis_cmd = 1'b1; @(negedge clk); dis_cmd = 1'b0;
    repeat (80) @(negedge clk);
    check("held while disabled, empty low", tx_empty, 1'b0);
    check("line idle while disabled", txd, 1'b1);
    en_cmd = 1'b1; dis_cmd = 1'b1; @(negedge clk); en_cmd = 1'b0; dis_cmd = 1'b0;
    repeat (20) @(negedge clk);
    check("disable wins over enable", tx_ready, 1'b0);
    en_cmd = 1'b1; @(negedge clk); en_cmd = 1'b0; drain();
    put(8'h0F); put(8'hF0);
    while (!bit_tick || q.size() != 1) @(negedge clk);
    dis_cmd = 1'b1; @(negedge clk); dis_cmd = 1'b0;
    repeat (30) @(negedge clk);
    en_cmd = 1'b1; @(negedge clk); en_cmd = 1'b0; drain();
    cur_req = "R5";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en   = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      dis_cmd = ($urandom % 97) == 0;
      en_cmd  = ($urandom % 13) == 0;
      if ($urandom % 50 == 0) begin
        data_len = 2'($urandom); parity_mode = 3'($urandom); two_stop = 1'($urandom);
      end
    end
    @(negedge clk);
    wr_en = 1'b0; dis_cmd = 1'b0; en_cmd = 1'b1;
    @(negedge clk); en_cmd = 1'b0;
    drain();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule